// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog for a processor subsystem. The system clock first passes through a linear divider, which divides by P+1 for an 8-bit setting P. It then passes through a power-of-two divider that divides by 16, 32, 64 or 128. Each pulse from the second divider is a tick, and each tick decrements a 16-bit down-counter. When a tick finds the counter at zero, the counter reloads from a 16-bit reload register. The same event can also set a sticky interrupt flag, start a fixed-length reset request pulse, or both. Two enables, one per output, choose which of these happens.

Software uses four word registers on a 32-bit bus. The bus has a write strobe and a combinational read port. Software keeps the system alive by writing the count register before it runs out. That write loads the new value and restarts both dividers, so the next tick is a full tick period away. The reload register can only change while counting is disabled. This keeps a running timer safe from a stray write that would shorten its timeout.

Top module: `presc_watchdog`

## Requirements
- R1: After synchronous reset the control register reads 0x00008021 (prescaler 0x80, counting enabled, reset request enabled), the reload and count registers read 0x8000, and both outputs are low.
- R2: Registers are addressed by byte offset: 0x0 control, 0x4 reload, 0x8 count, 0xC interrupt clear. Accesses with a nonzero offset[1:0] are ignored, and a count read returns the live counter. Control field positions: prescaler [15:8], count enable [5], divider select [4:3], interrupt enable [2], reset enable [0]; other bits read 0.
- R3: While enabled, the counter decrements once every (P+1)·2^(4+sel) clock cycles. The first tick comes exactly that many cycles after the edge that wrote the enable bit from 0 to 1.
- R4: With the count enable clear, the counter does not change and both dividers are held cleared.
- R5: A count register write loads bits [15:0] and clears both dividers. The next tick comes one full tick period after that write edge. A tick in the same cycle as the write is discarded.
- R6: A write to the reload register is discarded while the count enable is set. It takes effect while the enable is clear.
- R7: Starting from count value C, the expiry happens on tick C+1, and the counter then holds the reload value.
- R8: On expiry with the interrupt enable set, irq_out goes high and stays high until any write to offset 0xC. With the interrupt enable clear, expiry leaves it unchanged.
- R9: On expiry with the reset enable set, rst_req_out is high for exactly 4 clock cycles. With the reset enable clear, it stays low.
- R10: Writing control to 0, then count to 1, then control to 0x21 gives a reset request 32 cycles after the last write, which is two ticks at the fastest divide.
- R11: If an expiry that sets the interrupt falls in the same cycle as an interrupt-clear write, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the counting source |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_out | output | 1 | Sticky expiry interrupt |
| rst_req_out | output | 1 | Expiry reset request pulse |

## Verification
Two events can land on the same clock edge: an expiry that sets the interrupt flag, and a software write to the clear register. The bench starts the timer with the count at zero and the fastest divide. It then times the clear write to land exactly on the computed expiry edge, 16 cycles after the enable write. It judges the result by reading the flag afterwards: it must still be set, because a dropped event is worse than an extra one. A second collision places a count write on a tick edge, and the written value must win.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int PRESC_W   = 8;
    localparam int SEL_W     = 2;
    localparam int CNT_W     = 16;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int BASE_DIV_LOG = 4;
    localparam int DIV_W     = BASE_DIV_LOG + (1 << SEL_W) - 1;
    localparam int PULSE_CYC = 4;

    localparam logic [PRESC_W-1:0] RST_PRESC  = 8'h80;
    localparam logic [CNT_W-1:0]   RST_RELOAD = 16'h8000;
    localparam logic [CNT_W-1:0]   RST_COUNT  = 16'h8000;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_COUNT  = 2'd2,
        REG_CLEAR  = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic               run;
        logic [SEL_W-1:0]   sel;
        logic               irq_en;
        logic               rst_en;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
        return {16'h0000, c.presc, 2'b00, c.run, c.sel, c.irq_en, 1'b0, c.rst_en};
    endfunction

    function automatic logic [DIV_W-1:0] stage2_last(input logic [SEL_W-1:0] s);
        logic [DIV_W-1:0] one;
        one = '0;
        one[0] = 1'b1;
        return (one << (BASE_DIV_LOG + int'(s))) - one;
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  live_count,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_value,
    output logic              irq_clear,
    output logic [DATA_W-1:0] bus_rdata
);

    logic     aligned;
    reg_idx_e idx;
    logic     wr_en;
    logic     unused_wdata_bits;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign idx     = reg_idx_e'(bus_addr[3:2]);
    assign wr_en   = bus_sel && bus_wr && aligned;

    assign cnt_load  = wr_en && (idx == REG_COUNT);
    assign cnt_value = bus_wdata[CNT_W-1:0];
    assign irq_clear = wr_en && (idx == REG_CLEAR);

    assign unused_wdata_bits = ^{bus_wdata[DATA_W-1:16], bus_wdata[7:6], bus_wdata[1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.presc  <= RST_PRESC;
            ctrl.run    <= 1'b1;
            ctrl.sel    <= '0;
            ctrl.irq_en <= 1'b0;
            ctrl.rst_en <= 1'b1;
        end else if (wr_en && idx == REG_CTRL) begin
            ctrl.presc  <= bus_wdata[15:8];
            ctrl.run    <= bus_wdata[5];
            ctrl.sel    <= bus_wdata[4:3];
            ctrl.irq_en <= bus_wdata[2];
            ctrl.rst_en <= bus_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= RST_RELOAD;
        end else if (wr_en && idx == REG_RELOAD && !ctrl.run) begin
            reload <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (idx)
                REG_CTRL:   bus_rdata = ctrl_pack(ctrl);
                REG_RELOAD: bus_rdata[CNT_W-1:0] = reload;
                REG_COUNT:  bus_rdata[CNT_W-1:0] = live_count;
                REG_CLEAR:  bus_rdata = '0;
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R6: a running timer keeps its reload value across any bus activity
    p_reload_locked_r6: assert property (@(posedge clk) disable iff (rst)
        $past(ctrl.run) |-> reload == $past(reload));

endmodule

// File: rtl/wdog_tick.sv
module wdog_tick
    import wdog_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  restart,
    output logic  tick
);

    logic [PRESC_W-1:0] presc_cnt;
    logic [DIV_W-1:0]   div_cnt;
    logic               stage1;
    logic               stage2_wrap;

    assign stage1      = ctrl.run && (presc_cnt >= ctrl.presc);
    assign stage2_wrap = (div_cnt >= stage2_last(ctrl.sel));
    assign tick        = stage1 && stage2_wrap;

    always_ff @(posedge clk) begin
        if (rst || !ctrl.run || restart) begin
            presc_cnt <= '0;
            div_cnt   <= '0;
        end else begin
            if (stage1) begin
                presc_cnt <= '0;
                div_cnt   <= stage2_wrap ? '0 : div_cnt + 1'b1;
            end else begin
                presc_cnt <= presc_cnt + 1'b1;
            end
        end
    end

    // R3: the shortest tick period is 16 cycles, so ticks never abut
    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R4: no tick in the cycle right after counting is switched on
    p_no_tick_on_start_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.run) |-> !tick);

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int PULSE_LEN = PULSE_CYC
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic             tick,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_value,
    input  logic [CNT_W-1:0] reload,
    input  logic             irq_clear,
    output logic [CNT_W-1:0] count,
    output logic             irq_out,
    output logic             rst_req_out
);

    localparam int PW = $clog2(PULSE_LEN + 1);

    logic          expire;
    logic [PW-1:0] pulse_cnt;

    assign expire = tick && !cnt_load && (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= RST_COUNT;
        end else if (cnt_load) begin
            count <= cnt_value;
        end else if (tick) begin
            count <= (count == '0) ? reload : count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_out <= 1'b0;
        end else if (expire && ctrl.irq_en) begin
            irq_out <= 1'b1;
        end else if (irq_clear) begin
            irq_out <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_cnt <= '0;
        end else if (expire && ctrl.rst_en) begin
            pulse_cnt <= PW'(PULSE_LEN);
        end else if (pulse_cnt != '0) begin
            pulse_cnt <= pulse_cnt - 1'b1;
        end
    end

    assign rst_req_out = (pulse_cnt != '0);

    logic [7:0] hi_len;
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len <= '0;
        end else if (rst_req_out) begin
            hi_len <= (hi_len == 8'hFF) ? hi_len : hi_len + 1'b1;
        end else begin
            hi_len <= '0;
        end
    end

    // R9: a reset request never ends before its full length
    p_pulse_len_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_req_out) |-> hi_len >= 8'(PULSE_LEN));

    // R8: the interrupt flag only drops through a clear write
    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_out && !irq_clear) |=> irq_out);

    // R7: expiry brings the reload value into the counter
    p_expire_reload_r7: assert property (@(posedge clk) disable iff (rst)
        expire |=> count == $past(reload));

    // R5: a count write always wins over a tick
    p_load_wins_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_load |=> count == $past(cnt_value));

endmodule

// File: rtl/presc_watchdog.sv
module presc_watchdog
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out,
    output logic              rst_req_out
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cnt_value;
    logic             cnt_load;
    logic             irq_clear;
    logic             tick;

    wdog_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .live_count (count),
        .ctrl       (ctrl),
        .reload     (reload),
        .cnt_load   (cnt_load),
        .cnt_value  (cnt_value),
        .irq_clear  (irq_clear),
        .bus_rdata  (bus_rdata)
    );

    wdog_tick u_tick (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .restart (cnt_load),
        .tick    (tick)
    );

    wdog_core #(.PULSE_LEN(PULSE_CYC)) u_core (
        .clk         (clk),
        .rst         (rst),
        .ctrl        (ctrl),
        .tick        (tick),
        .cnt_load    (cnt_load),
        .cnt_value   (cnt_value),
        .reload      (reload),
        .irq_clear   (irq_clear),
        .count       (count),
        .irq_out     (irq_out),
        .rst_req_out (rst_req_out)
    );

    // R2: an expiry output never rises while counting is off
    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(ctrl.run) && !ctrl.run) |-> !$rose(irq_out));

endmodule

// File: tb/sim_presc_watchdog.sv
module sim_presc_watchdog;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    logic        rst_req_out;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    presc_watchdog u0 (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq_out     (irq_out),
        .rst_req_out (rst_req_out)
    );

    localparam logic [3:0] A_CTRL = 4'h0, A_RLD = 4'h4, A_CNT = 4'h8, A_CLR = 4'hC;

    function automatic int exp_period(input int p, input int s);
        return (p + 1) << (4 + s);
    endfunction

    function automatic logic [31:0] mk_ctrl(input int p, input int s, input bit run,
                                            input bit ie, input bit re);
        return (32'(p) << 8) | (32'(run) << 5) | (32'(s) << 3) | (32'(ie) << 2) | 32'(re);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_cnt_change(input logic [15:0] from, output int j);
        logic [31:0] v;
        j = 0;
        rd(A_CNT, v);
        while (v[15:0] == from && j < 40000) begin
            @(negedge clk); j++;
            rd(A_CNT, v);
        end
    endtask

    task automatic wait_sig(input bit which_irq, output int j);
        j = 0;
        while (((which_irq ? irq_out : rst_req_out) == 1'b0) && j < 40000) begin
            @(negedge clk); j++;
        end
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic measure(input int p, input int s);
        int j;
        wr(A_CTRL, 32'h0);
        wr(A_CNT, 32'd100);
        wr(A_CTRL, mk_ctrl(p, s, 1, 0, 0));
        wait_cnt_change(16'd100, j);
        check($sformatf("R3 period p=%0d sel=%0d", p, s), 32'(j), 32'(exp_period(p, s)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
    end

    initial begin
        logic [31:0] v;
        int j, n, hi;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v); check("R1 ctrl", v, 32'h0000_8021);
        rd(A_RLD, v);  check("R1 reload", v, 32'h0000_8000);
        check("R1 irq", 32'(irq_out), 0);
        check("R1 rst_req", 32'(rst_req_out), 0);

        // R2 register map, unused bits read 0, misaligned write ignored
        wr(A_CTRL, 32'hFFFF_FFDF);
        rd(A_CTRL, v); check("R2 ctrl fields", v, 32'h0000_FF1D);
        wr(A_RLD, 32'h0000_1234);
        wr(4'h5, 32'h0000_5555);
        rd(A_RLD, v); check("R2 reload offset / misaligned", v, 32'h0000_1234);
        wr(A_CNT, 32'hABCD_0077);
        rd(A_CNT, v); check("R2 count readback", v, 32'h0000_0077);

        // R4 disabled: counter frozen
        wr(A_CTRL, 32'h0);
        wr(A_CNT, 32'd9);
        repeat (200) @(negedge clk);
        rd(A_CNT, v); check("R4 frozen when off", v, 32'd9);

        // R3 periods: directed corners then random
        measure(0, 0);
        measure(255, 3);
        for (int k = 0; k < 6; k++) begin
            measure(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)));
        end

        // R5 count write restarts dividers
        wr(A_CTRL, 32'h0);
        wr(A_CNT, 32'd50);
        wr(A_CTRL, mk_ctrl(3, 1, 1, 0, 0));
        repeat (60) @(negedge clk);
        wr(A_CNT, 32'd40);
        wait_cnt_change(16'd40, j);
        check("R5 restart period", 32'(j), 32'(exp_period(3, 1)));
        rd(A_CNT, v); check("R5 after restart", v, 32'd39);

        // R5 collision: count write on the tick edge (tick at 16 after enable)
        wr(A_CTRL, 32'h0);
        wr(A_CNT, 32'd20);
        wr(A_CTRL, mk_ctrl(0, 0, 1, 0, 0));
        repeat (15) @(negedge clk);
        wr(A_CNT, 32'd300);
        rd(A_CNT, v); check("R5 write beats tick", v, 32'd300);

        // R6 reload locked while running
        wr(A_RLD, 32'd7);
        wr(A_CTRL, 32'h0);
        rd(A_RLD, v); check("R6 blocked while running", v, 32'h1234);
        wr(A_RLD, 32'd3);
        rd(A_RLD, v); check("R6 accepted while stopped", v, 32'd3);

        // R7 / R8 timeout with interrupt only
        wr(A_CLR, 32'h0);
        wr(A_CNT, 32'd3);
        wr(A_CTRL, mk_ctrl(1, 0, 1, 1, 0));
        wait_sig(1'b1, j);
        check("R7 timeout cycles", 32'(j), 32'(4 * exp_period(1, 0)));
        rd(A_CNT, v); check("R7 reload after expiry", v, 32'd3);
        hi = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (rst_req_out) hi++;
        end
        check("R9 no reset when disabled", 32'(hi), 0);
        check("R8 sticky", 32'(irq_out), 1);
        wr(A_CLR, 32'h0);
        check("R8 cleared", 32'(irq_out), 0);

        // R9 reset pulse length, interrupt enable off
        wr(A_CTRL, 32'h0);
        wr(A_RLD, 32'd1);
        wr(A_CNT, 32'd0);
        wr(A_CTRL, mk_ctrl(0, 0, 1, 0, 1));
        wait_sig(1'b0, j);
        check("R9 first expiry", 32'(j), 32'(exp_period(0, 0)));
        n = 0;
        while (rst_req_out && n < 50) begin
            n++; @(negedge clk);
        end
        check("R9 pulse width", 32'(n), 32'd4);
        check("R8 no irq when disabled", 32'(irq_out), 0);

        // R10 stop, load 1, start with reset enable
        wr(A_CTRL, 32'h0);
        wr(A_CNT, 32'd1);
        wr(A_CTRL, 32'h21);
        wait_sig(1'b0, j);
        check("R10 reset after sequence", 32'(j), 32'd32);

        // R11 clear write on the same edge as expiry
        wr(A_CTRL, 32'h0);
        wr(A_CLR, 32'h0);
        wr(A_CNT, 32'd0);
        wr(A_CTRL, mk_ctrl(0, 0, 1, 1, 0));
        repeat (15) @(negedge clk);
        wr(A_CLR, 32'h0);
        check("R11 set wins over clear", 32'(irq_out), 1);

        summary();
    end

endmodule